// File: doc/BRIEF.md
# Pulse-Width Qualified Data Squelch

This block sits behind an on-off keyed demodulator and stops random noise chatter from reaching the data output. Every run of the raw data input at one level, high or low, is timed in clock cycles and judged against a minimum width. The minimum width comes from a 2-bit select input. The block keeps a sliding record of the last eight judged pulses. It opens the output gate once enough of them are long enough, and it closes the gate again when too few are. A dead band between the two thresholds keeps the gate steady.

The squelch acts only while the active-low enable is driven low. With the enable high, the raw input is passed straight through. While the gate is closed the output is held low. When the gate opens, the live input is passed from the next clock on. Pulses that were already judged are never replayed. The four minimum widths are parameters given in clock cycles, so one build can serve any carrier frequency or tick rate. The defaults assume 1 MHz ticks: 305, 152, 76 and 38 cycles.

Top module: `pulse_squelch`

## Requirements
- R1: While `sq_en_n` is 1, `dout` equals `din` combinationally in every cycle.
- R2: After reset the gate is closed and the pulse history holds zero good pulses, so with `sq_en_n` at 0 `dout` is 0 whatever `din` is.
- R3: A pulse is the run of consecutive clock samples of `din` at one level. It is judged at the clock edge that samples the opposite level. It is good when its sample count is strictly greater than the selected threshold. High and low pulses are judged by the same rule.
- R4: `wsel` picks the threshold at the judging edge: 2'b00 selects `TH_SEL0` (longest), 2'b01 selects `TH_SEL1`, 2'b10 selects `TH_SEL2` and 2'b11 selects `TH_SEL3` (shortest).
- R5: The good/bad results of the most recent eight judged pulses form the window. Each judged pulse pushes out the oldest result.
- R6: When four or fewer of the window entries are good, the gate is closed at the next clock edge.
- R7: When seven or more window entries are good, the gate is open at the next clock edge. This is one clock after the edge that judged the deciding pulse.
- R8: With five or six good entries in the window, the gate keeps its previous state.
- R9: The width counter saturates at 2^`CNT_W`-1. A pulse that reaches saturation is recorded as good when its closing edge arrives, whatever its length.
- R10: While `sq_en_n` is 0, `dout` is `din` when the gate is open and 0 when it is closed. Earlier pulses are not replayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one cycle is one width tick |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Raw demodulated data |
| sq_en_n | input | 1 | Squelch enable, active low; 1 passes `din` straight through |
| wsel | input | 2 | Minimum pulse width select |
| dout | output | 1 | Gated data |

## Verification
A corrupted pulse history or a gate register stuck in the wrong state shows up at `dout` in one of two ways. Either a wrong level appears while `din` is high with the squelch enabled, or the gate opens or closes one or more pulses too early or too late. The bench follows the gate decision cycle by cycle from its own run-length model, so an error in the judging edge or in the one-clock gate delay appears on the first high input cycle after the faulty decision. An off-by-one in the width comparison flips the judgement of pulses that sit exactly on a threshold. The directed boundary pulses turn that into a wrong gate state within eight pulses.

// File: rtl/pulse_squelch_pkg.sv
package pulse_squelch_pkg;

   // Width select codes, longest minimum width first.
   typedef enum logic [1:0] {
      WSEL_W0 = 2'b00,
      WSEL_W1 = 2'b01,
      WSEL_W2 = 2'b10,
      WSEL_W3 = 2'b11
   } wsel_e;

   localparam int unsigned NUM_WSEL = 4;

endpackage

// File: rtl/pulse_timer.sv
module pulse_timer
   import pulse_squelch_pkg::*;
#(
   parameter int unsigned CNT_W   = 9,
   parameter int unsigned TH_SEL0 = 305,
   parameter int unsigned TH_SEL1 = 152,
   parameter int unsigned TH_SEL2 = 76,
   parameter int unsigned TH_SEL3 = 38
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic [1:0] wsel,
   output logic       pulse_done,
   output logic       pulse_good
);

   localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] TH_TBL [NUM_WSEL] = '{
      CNT_W'(TH_SEL0), CNT_W'(TH_SEL1), CNT_W'(TH_SEL2), CNT_W'(TH_SEL3)
   };

   logic             lvl_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] th_cur;

   assign th_cur     = TH_TBL[wsel];
   assign pulse_done = din ^ lvl_q;
   assign pulse_good = (len_q > th_cur) || (len_q == LEN_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         len_q <= '0;
      end else begin
         lvl_q <= din;
         if (pulse_done)
            len_q <= CNT_W'(1);
         else if (len_q != LEN_MAX)
            len_q <= len_q + 1'b1;
      end
   end

endmodule

// File: rtl/pulse_history.sv
module pulse_history #(
   parameter int unsigned WIN = 8,
   parameter int unsigned CW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          good,
   output logic [CW-1:0] good_cnt
);

   logic [WIN-1:0] hist_q;

   // One flop per window slot; slot 0 takes the newest result.
   genvar gi;
   generate
      for (gi = 0; gi < WIN; gi++) begin : g_slot
         logic nxt;
         if (gi == 0) begin : g_head
            assign nxt = good;
         end else begin : g_body
            assign nxt = hist_q[gi-1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)
               hist_q[gi] <= 1'b0;
            else if (push)
               hist_q[gi] <= nxt;
         end
      end
   endgenerate

   always_comb begin
      good_cnt = '0;
      for (int i = 0; i < WIN; i++)
         good_cnt = good_cnt + CW'(hist_q[i]);
   end

endmodule

// File: rtl/squelch_gate.sv
module squelch_gate #(
   parameter int unsigned CW       = 4,
   parameter int unsigned OPEN_AT  = 7,
   parameter int unsigned CLOSE_AT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] good_cnt,
   output logic          open_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (good_cnt >= CW'(OPEN_AT))
         open_q <= 1'b1;
      else if (good_cnt <= CW'(CLOSE_AT))
         open_q <= 1'b0;
   end

endmodule

// File: rtl/pulse_squelch.sv
module pulse_squelch #(
   parameter int unsigned CNT_W    = 9,
   parameter int unsigned TH_SEL0  = 305,
   parameter int unsigned TH_SEL1  = 152,
   parameter int unsigned TH_SEL2  = 76,
   parameter int unsigned TH_SEL3  = 38,
   parameter int unsigned WIN      = 8,
   parameter int unsigned OPEN_AT  = 7,
   parameter int unsigned CLOSE_AT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic       sq_en_n,
   input  logic [1:0] wsel,
   output logic       dout
);

   localparam int unsigned CW_CNT  = $clog2(WIN + 1);
   localparam int unsigned LEN_TOP = (1 << CNT_W) - 1;

   generate
      if (TH_SEL0 >= LEN_TOP || TH_SEL1 >= LEN_TOP ||
          TH_SEL2 >= LEN_TOP || TH_SEL3 >= LEN_TOP) begin : g_bad_th
         $error("pulse_squelch: thresholds must be below counter saturation");
      end
      if (!(CLOSE_AT < OPEN_AT && OPEN_AT <= WIN)) begin : g_bad_hyst
         $error("pulse_squelch: need CLOSE_AT < OPEN_AT <= WIN");
      end
      if (WIN < 2) begin : g_bad_win
         $error("pulse_squelch: window must hold at least two pulses");
      end
   endgenerate

   logic              pulse_done;
   logic              pulse_good;
   logic [CW_CNT-1:0] good_cnt;
   logic              open_q;

   pulse_timer #(
      .CNT_W  (CNT_W),
      .TH_SEL0(TH_SEL0),
      .TH_SEL1(TH_SEL1),
      .TH_SEL2(TH_SEL2),
      .TH_SEL3(TH_SEL3)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .wsel      (wsel),
      .pulse_done(pulse_done),
      .pulse_good(pulse_good)
   );

   pulse_history #(
      .WIN(WIN),
      .CW (CW_CNT)
   ) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (pulse_done),
      .good    (pulse_good),
      .good_cnt(good_cnt)
   );

   squelch_gate #(
      .CW      (CW_CNT),
      .OPEN_AT (OPEN_AT),
      .CLOSE_AT(CLOSE_AT)
   ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .good_cnt(good_cnt),
      .open_q  (open_q)
   );

   assign dout = sq_en_n ? din : (open_q & din);

endmodule

// File: rtl/pulse_squelch_chk.sv
module pulse_squelch_chk #(
   parameter int unsigned CW       = 4,
   parameter int unsigned WIN      = 8,
   parameter int unsigned OPEN_AT  = 7,
   parameter int unsigned CLOSE_AT = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          din,
   input logic          sq_en_n,
   input logic          dout,
   input logic          open_q,
   input logic          pulse_done,
   input logic [CW-1:0] good_cnt
);

   a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      sq_en_n |-> (dout == din));

   a_r10_closed_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sq_en_n && !open_q) |-> !dout);

   a_r10_open_live: assert property (@(posedge clk) disable iff (!rst_n)
      (!sq_en_n && open_q) |-> (dout == din));

   a_r6_close: assert property (@(posedge clk) disable iff (!rst_n)
      (good_cnt <= CW'(CLOSE_AT)) |=> !open_q);

   a_r7_open: assert property (@(posedge clk) disable iff (!rst_n)
      (good_cnt >= CW'(OPEN_AT)) |=> open_q);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (good_cnt > CW'(CLOSE_AT) && good_cnt < CW'(OPEN_AT)) |=> $stable(open_q));

   a_r5_only_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_done |=> $stable(good_cnt));

   a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
      good_cnt <= CW'(WIN));

   a_r2_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!open_q && good_cnt == '0));

endmodule

bind pulse_squelch pulse_squelch_chk #(
   .CW      (CW_CNT),
   .WIN     (WIN),
   .OPEN_AT (OPEN_AT),
   .CLOSE_AT(CLOSE_AT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .din       (din),
   .sq_en_n   (sq_en_n),
   .dout      (dout),
   .open_q    (open_q),
   .pulse_done(pulse_done),
   .good_cnt  (good_cnt)
);

// File: tb/pulse_squelch_bench.sv
`timescale 1ns/1ps
module pulse_squelch_bench;

   localparam int unsigned BW   = 6;
   localparam int unsigned T0   = 40;
   localparam int unsigned T1   = 20;
   localparam int unsigned T2   = 10;
   localparam int unsigned T3   = 5;
   localparam int unsigned SATV = (1 << BW) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       din = 1'b0;
   logic       sq_en_n = 1'b0;
   logic [1:0] wsel = 2'b11;
   logic       dout;

   int unsigned nvec = 0;
   int unsigned nfail = 0;
   bit          done = 1'b0;
   string       cur_req = "R2";

   // Requirement model state
   logic       m_lvl;
   int unsigned m_len;
   logic [7:0] m_hist;
   logic       m_open;

   always #4 clk = ~clk;

   pulse_squelch #(
      .CNT_W  (BW),
      .TH_SEL0(T0),
      .TH_SEL1(T1),
      .TH_SEL2(T2),
      .TH_SEL3(T3)
   ) u_pulse_squelch (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (din),
      .sq_en_n(sq_en_n),
      .wsel   (wsel),
      .dout   (dout)
   );

   function automatic int unsigned th_of(input logic [1:0] s);
      case (s)
         2'b00:   return T0;
         2'b01:   return T1;
         2'b10:   return T2;
         default: return T3;
      endcase
   endfunction

   function automatic logic next_open(input logic [7:0] h, input logic cur);
      int unsigned c;
      c = $countones(h);
      if (c >= 7) return 1'b1;
      if (c <= 4) return 1'b0;
      return cur;
   endfunction

   function automatic logic exp_dout(input logic en_n, input logic d, input logic op);
      return en_n ? d : (op & d);
   endfunction

   task automatic check_out();
      logic e;
      e = exp_dout(sq_en_n, din, m_open);
      nvec++;
      if (dout !== e) begin
         nfail++;
         $display("FAIL %s: dout=%b expected %b (din=%b en_n=%b wsel=%b)",
                  cur_req, dout, e, din, sq_en_n, wsel);
      end
   endtask

   task automatic model_edge();
      logic g;
      logic nopen;
      nopen = next_open(m_hist, m_open);
      if (din !== m_lvl) begin
         g = (m_len > th_of(wsel)) || (m_len == SATV);
         m_hist = {m_hist[6:0], g};
         m_len = 1;
      end else if (m_len != SATV) begin
         m_len++;
      end
      m_lvl = din;
      m_open = nopen;
   endtask

   task automatic step(input logic v, input logic en_n, input logic [1:0] s);
      @(negedge clk);
      din = v;
      sq_en_n = en_n;
      wsel = s;
      #1;
      check_out();
      @(posedge clk);
      model_edge();
   endtask

   task automatic pulse(input logic v, input int unsigned n, input logic en_n,
                        input logic [1:0] s);
      for (int i = 0; i < n; i++) step(v, en_n, s);
   endtask

   task automatic pulses(input int unsigned cnt, input int unsigned n,
                         input logic [1:0] s);
      for (int i = 0; i < cnt; i++) pulse(~m_lvl, n, 1'b0, s);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'd7117));
      m_lvl = 1'b0; m_len = 0; m_hist = '0; m_open = 1'b0;
      repeat (4) @(posedge clk);
      // R2: closed gate with squelch enabled, during and right after reset
      @(negedge clk); din = 1'b1; #1;
      nvec++;
      if (dout !== 1'b0) begin
         nfail++;
         $display("FAIL R2: dout=%b expected 0 in reset", dout);
      end
      din = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cur_req = "R2";
      step(1'b1, 1'b0, 2'b11);
      step(1'b1, 1'b0, 2'b11);

      // R7: seven long pulses open the gate one clock after the deciding edge
      cur_req = "R7";
      pulses(9, 8, 2'b11);
      step(~m_lvl, 1'b0, 2'b11);
      pulse(m_lvl, 5, 1'b0, 2'b11);

      // R8: short pulses bring count to 6 then 5, gate holds open
      cur_req = "R8";
      pulses(3, 2, 2'b11);
      pulse(1'b1, 6, 1'b0, 2'b11);

      // R6: further short pulses close the gate
      cur_req = "R6";
      pulses(6, 3, 2'b11);
      pulse(~m_lvl, 4, 1'b0, 2'b11);

      // R3/R4: exactly-at-threshold widths are bad on longest select
      cur_req = "R3";
      pulses(10, T0, 2'b00);
      pulse(1'b1, 4, 1'b0, 2'b00);
      cur_req = "R4";
      pulses(10, T0 + 1, 2'b00);
      pulse(1'b1, 4, 1'b0, 2'b00);
      pulses(10, T1, 2'b01);
      pulses(10, T2 + 1, 2'b10);
      pulse(1'b1, 3, 1'b0, 2'b10);

      // R5: window slides; old good results age out
      cur_req = "R5";
      pulses(8, 1, 2'b11);
      pulses(6, 9, 2'b11);
      pulse(1'b1, 3, 1'b0, 2'b11);

      // R9: saturated pulses count good even on longest select
      cur_req = "R9";
      pulses(10, 1, 2'b00);
      pulses(9, SATV + 6, 2'b00);
      pulse(1'b1, 3, 1'b0, 2'b00);

      // R1: bypass with gate closed
      cur_req = "R1";
      pulses(10, 1, 2'b00);
      for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)), 1'b1, 2'b00);

      // R10: random mix
      cur_req = "R10";
      for (int k = 0; k < 500; k++) begin
         logic [1:0] s;
         logic en;
         int unsigned n;
         s  = 2'($urandom_range(0, 3));
         en = ($urandom_range(0, 9) == 0);
         n  = 1 + $urandom_range(0, 2 * th_of(s) + 2);
         if ($urandom_range(0, 49) == 0) n = SATV + 3;
         pulse(~m_lvl, n, en, s);
      end
      summary();
   end

endmodule